// File: doc/BRIEF.md
# Boot Start-Address and Mode Fetch Sequencer

This block sits between the reset controller and the memory bus of a CPU with a 24-bit address space. When reset is released, it reads a fixed four-byte window at the top of the address space. The window starts at 0xFFFFDC. The first three bytes form a little-endian 24-bit start address. The upper byte of that address goes to the program bank register and the lower sixteen bits go to the program counter. The fourth byte is captured into a mode register, and nothing else can write that register.

A strap pin, sampled on the first clock after reset release, chooses whether the window is read from internal ROM or from external memory. Each byte is read with a request/valid handshake. The sequencer moves to the next address only after the selected source returns valid. While the sequence runs, a hold output keeps the CPU from fetching instructions. A one-cycle done pulse marks the end. Asserting reset at any point aborts the sequence, and the sequence restarts from the first byte on the next release.

Top module: `boot_vector_fetch`

## Requirements
- R1: While rstN is low, romReq, extReq and done are 0, cpuHold is 1, and pc, pcBank and modeReg are 0.
- R2: On the first clock edge with rstN high, the block starts fetching. From the next cycle on, a request is raised with busAddr = 0xFFFFDC.
- R3: Bytes are requested one at a time in ascending address order, 0xFFFFDC to 0xFFFFDF. busAddr holds its value until the selected source returns valid at a clock edge.
- R4: The byte at 0xFFFFDC becomes pc[7:0], the byte at 0xFFFFDD becomes pc[15:8], and the byte at 0xFFFFDE becomes pcBank[7:0]. pc and pcBank change only at the edge that captures the byte at 0xFFFFDF.
- R5: The byte at 0xFFFFDF is loaded into modeReg at that same edge. At no other time does modeReg change, except when it is cleared by reset.
- R6: If extVecPin was 1 when it was sampled, only extReq is used for all four reads. If it was 0, only romReq is used. Data and valid are taken only from the selected source.
- R7: extVecPin is sampled only on the first edge after reset release. A later change on the pin has no effect on the source used.
- R8: A valid from the unselected source, or a valid while no request is raised, is ignored.
- R9: done is high for exactly one cycle. That cycle directly follows the edge that captures the last byte. cpuHold is 1 from reset until that cycle and 0 from then on.
- R10: After done, no further requests are raised, and pc, pcBank and modeReg stay constant until the next reset.
- R11: A reset during a sequence aborts it. After release, fetching restarts at 0xFFFFDC.
- R12: romReq and extReq are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extVecPin | input | 1 | Strap: 1 = read the window from external memory, 0 = internal ROM |
| busAddr | output | 24 | Byte address of the current read |
| romReq | output | 1 | Read request to internal ROM |
| romData | input | 8 | Read data from internal ROM |
| romValid | input | 1 | romData valid for the current request |
| extReq | output | 1 | Read request to external memory |
| extData | input | 8 | Read data from external memory |
| extValid | input | 1 | extData valid for the current request |
| pcBank | output | 8 | Program bank register (start address bits 23:16) |
| pc | output | 16 | Program counter (start address bits 15:0) |
| modeReg | output | 8 | Captured mode byte |
| done | output | 1 | One-cycle pulse when the sequence finishes |
| cpuHold | output | 1 | Blocks instruction fetch until the sequence finishes |

## Verification
The bench flips the strap pin in the middle of a sequence. A design that resampled the pin would switch its request to the other source and load that source's bytes. It also keeps the unselected source's valid pulsing with junk data. A design that ORed the two valids would run ahead and capture 0xEE bytes. Responses come with latencies of zero to three cycles, so an address that advanced before valid, or a byte stored in the wrong lane, shows up as a wrong address or a swapped pc byte. A reset lands mid-sequence after an earlier run has already loaded pc. A design that failed to clear its state or its byte index would keep the old pc or resume at a later address.

// File: rtl/bvf_pkg.sv
package bvf_pkg;
  localparam int ADDR_W    = 24;
  localparam int DATA_W    = 8;
  localparam int WIN_BYTES = 4;
  localparam int VEC_BYTES = WIN_BYTES - 1;
  localparam int IDX_W     = $clog2(WIN_BYTES);
  localparam int PC_W      = 16;
  localparam int BANK_W    = ADDR_W - PC_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_FIN,
    ST_RUN
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] byteIdx;
    logic             loadStart;
    logic             useExt;
  } dpCtrl_t;
endpackage

// File: rtl/bvf_ctrl.sv
module bvf_ctrl
  import bvf_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_BASE = 24'hFFFFDC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extVecPin,
  input  logic              romValid,
  input  logic              extValid,
  output dpCtrl_t           ctl,
  output logic              romReq,
  output logic              extReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic              done,
  output logic              cpuHold
);
  seqState_t        state;
  logic [IDX_W-1:0] idx;
  logic             useExt;
  logic             fetching;
  logic             selValid;
  logic             beat;
  logic             lastBeat;

  assign fetching = (state == ST_FETCH);
  assign selValid = useExt ? extValid : romValid;
  assign beat     = fetching && selValid;
  assign lastBeat = beat && (idx == IDX_W'(WIN_BYTES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      idx    <= '0;
      useExt <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          useExt <= extVecPin;   // strap latched once per release
          idx    <= '0;
          state  <= ST_FETCH;
        end
        ST_FETCH: begin
          if (lastBeat)  state <= ST_FIN;
          else if (beat) idx   <= idx + 1'b1;
        end
        ST_FIN:  state <= ST_RUN;
        default: state <= ST_RUN;
      endcase
    end
  end

  assign romReq  = fetching && !useExt;
  assign extReq  = fetching && useExt;
  assign busAddr = WIN_BASE + ADDR_W'(idx);
  assign done    = (state == ST_FIN);
  assign cpuHold = (state == ST_IDLE) || (state == ST_FETCH);

  always_comb begin
    ctl.capture   = beat;
    ctl.byteIdx   = idx;
    ctl.loadStart = lastBeat;
    ctl.useExt    = useExt;
  end

  a_r12_one_source: assert property (@(posedge clk) disable iff (!rstN)
    !(romReq && extReq));
  a_r3_addr_waits: assert property (@(posedge clk) disable iff (!rstN)
    (romReq || extReq) && !selValid |=> $stable(busAddr));
  a_r7_source_kept: assert property (@(posedge clk) disable iff (!rstN)
    romReq |=> !extReq);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r9_hold_released: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !cpuHold);
  a_r10_quiet_after: assert property (@(posedge clk) disable iff (!rstN)
    $past(done) |-> !(romReq || extReq));
endmodule

// File: rtl/bvf_datapath.sv
module bvf_datapath
  import bvf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [DATA_W-1:0] romData,
  input  logic [DATA_W-1:0] extData,
  output logic [BANK_W-1:0] pcBank,
  output logic [PC_W-1:0]   pc,
  output logic [DATA_W-1:0] modeReg
);
  logic [DATA_W-1:0] rdByte;
  logic [ADDR_W-1:0] acc;

  assign rdByte = ctl.useExt ? extData : romData;

  // one byte lane per start-address byte, little-endian
  for (genvar g = 0; g < VEC_BYTES; g++) begin : g_lane
    logic [DATA_W-1:0] laneQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        laneQ <= '0;
      else if (ctl.capture && ctl.byteIdx == IDX_W'(g))
        laneQ <= rdByte;
    end
    assign acc[g*DATA_W +: DATA_W] = laneQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc      <= '0;
      pcBank  <= '0;
      modeReg <= '0;
    end else if (ctl.loadStart) begin
      pc      <= acc[PC_W-1:0];
      pcBank  <= acc[ADDR_W-1:PC_W];
      modeReg <= rdByte;
    end
  end

  a_r5_mode_locked: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadStart |=> $stable(modeReg));
  a_r4_pc_locked: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadStart |=> $stable(pc) && $stable(pcBank));
endmodule

// File: rtl/boot_vector_fetch.sv
module boot_vector_fetch
  import bvf_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_BASE = 24'hFFFFDC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extVecPin,
  output logic [ADDR_W-1:0] busAddr,
  output logic              romReq,
  input  logic [DATA_W-1:0] romData,
  input  logic              romValid,
  output logic              extReq,
  input  logic [DATA_W-1:0] extData,
  input  logic              extValid,
  output logic [BANK_W-1:0] pcBank,
  output logic [PC_W-1:0]   pc,
  output logic [DATA_W-1:0] modeReg,
  output logic              done,
  output logic              cpuHold
);
  dpCtrl_t ctl;

  bvf_ctrl #(.WIN_BASE(WIN_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .extVecPin(extVecPin),
    .romValid(romValid), .extValid(extValid), .ctl(ctl),
    .romReq(romReq), .extReq(extReq), .busAddr(busAddr),
    .done(done), .cpuHold(cpuHold)
  );

  bvf_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .romData(romData), .extData(extData),
    .pcBank(pcBank), .pc(pc), .modeReg(modeReg)
  );

  // R1: reset state of the hold output
  a_r1_hold_in_reset: assert property (@(posedge clk) !rstN |-> cpuHold && !done);
endmodule

// File: tb/sim_boot_vector_fetch.sv
module sim_boot_vector_fetch;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0, extVecPin = 1'b0, romValid = 1'b0, extValid = 1'b0;
  logic [7:0]  romData = '0, extData = '0;
  logic [23:0] busAddr;
  logic        romReq, extReq, done, cpuHold;
  logic [7:0]  pcBank, modeReg;
  logic [15:0] pc;

  boot_vector_fetch u0 (
    .clk(clk), .rstN(rstN), .extVecPin(extVecPin), .busAddr(busAddr),
    .romReq(romReq), .romData(romData), .romValid(romValid),
    .extReq(extReq), .extData(extData), .extValid(extValid),
    .pcBank(pcBank), .pc(pc), .modeReg(modeReg), .done(done), .cpuHold(cpuHold)
  );

  int errors = 0, checks = 0, cyc = 0, latency = 0, wc = 0;
  bit noise = 0;
  logic [7:0] romMem [4];
  logic [7:0] extMem [4];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  int mSt = 0, mIdx = 0;
  bit mExt = 0;
  logic [23:0] mAcc = '0;
  logic [15:0] mPc = '0;
  logic [7:0]  mBank = '0, mMode = '0;
  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mIdx = 0; mExt = 0; mAcc = '0; mPc = '0; mBank = '0; mMode = '0;
    end else if (mSt == 0) begin
      mExt = extVecPin; mIdx = 0; mSt = 1;
    end else if (mSt == 1) begin
      if (mExt ? extValid : romValid) begin
        logic [7:0] d;
        d = mExt ? extData : romData;
        if (mIdx == 3) begin
          mPc = mAcc[15:0]; mBank = mAcc[23:16]; mMode = d; mSt = 2;
        end else begin
          mAcc[mIdx*8 +: 8] = d; mIdx++;
        end
      end
    end else begin
      mSt = 3;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    chk("R6 romReq", romReq, (mSt == 1 && !mExt));
    chk("R6 extReq", extReq, (mSt == 1 && mExt));
    if (mSt == 1) chk("R3 busAddr", busAddr, 24'hFFFFDC + mIdx);
    chk("R4 pc", pc, mPc);
    chk("R4 pcBank", pcBank, mBank);
    chk("R5 modeReg", modeReg, mMode);
    chk("R9 done", done, (mSt == 2));
    chk("R9 cpuHold", cpuHold, (mSt < 2));
    chk("R12 single request", romReq & extReq, 0);
  end

  // memory responders, driven just after the falling edge
  always @(negedge clk) begin
    #1;
    romValid = 1'b0; extValid = 1'b0;
    if (romReq || extReq) begin
      if (wc >= latency) begin
        wc = 0;
        if (romReq) begin romValid = 1'b1; romData = romMem[busAddr[1:0]]; end
        else        begin extValid = 1'b1; extData = extMem[busAddr[1:0]]; end
      end else wc++;
    end
    if (noise) begin
      if (!romReq) begin romValid = 1'b1; romData = 8'hEE; end
      if (!extReq) begin extValid = 1'b1; extData = 8'hEE; end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      checks++; errors++;
      $display("FAIL R9 watchdog act=%0d exp=<%0d", cyc, 20000);
      summary();
      $finish;
    end
  end

  task automatic doReset(bit pin);
    @(negedge clk); #1;
    rstN = 1'b0; extVecPin = pin; wc = 0;
    repeat (2) @(negedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic waitDone(string tag);
    bit seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
    chk(tag, seen, 1);
  endtask

  initial begin
    romMem[0] = 8'h34; romMem[1] = 8'h12; romMem[2] = 8'hAB; romMem[3] = 8'h5A;
    extMem[0] = 8'hC1; extMem[1] = 8'h7E; extMem[2] = 8'h02; extMem[3] = 8'hA5;

    // R1: state held in reset
    repeat (3) @(negedge clk);
    chk("R1 cpuHold in reset", cpuHold, 1);
    chk("R1 no request in reset", romReq | extReq, 0);
    chk("R1 pc in reset", {pcBank, pc, modeReg}, 0);

    // internal ROM, no wait states
    latency = 0;
    doReset(0);
    @(negedge clk);
    chk("R2 first request", {romReq, busAddr}, {1'b1, 24'hFFFFDC});
    waitDone("R9 done seen rom");
    chk("R4 start address rom", {pcBank, pc}, 24'hAB1234);
    chk("R5 mode rom", modeReg, 8'h5A);
    repeat (8) @(negedge clk);
    chk("R10 no request after done", romReq | extReq, 0);
    chk("R10 pc stable", {pcBank, pc, modeReg}, 32'hAB12345A);

    // external memory, two wait states
    latency = 2;
    doReset(1);
    waitDone("R9 done seen ext");
    chk("R6 start address ext", {pcBank, pc}, 24'h027EC1);
    chk("R6 mode ext", modeReg, 8'hA5);

    // R7: strap flips mid-sequence
    latency = 1;
    doReset(0);
    repeat (3) @(negedge clk);
    #1 extVecPin = 1'b1;
    waitDone("R7 done seen");
    chk("R7 source kept", {pcBank, pc, modeReg}, 32'hAB12345A);

    // R8: unselected source chatters
    latency = 3; noise = 1;
    doReset(1);
    waitDone("R8 done seen");
    chk("R8 noise ignored", {pcBank, pc, modeReg}, 32'h027EC1A5);
    noise = 0;

    // R11: abort mid-sequence
    latency = 0;
    doReset(0);
    @(negedge clk); @(negedge clk); @(negedge clk);
    #1 rstN = 1'b0;
    @(negedge clk);
    chk("R11 cleared by abort", {cpuHold, pcBank, pc, modeReg}, {1'b1, 32'h0});
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R11 restart address", {romReq, busAddr}, {1'b1, 24'hFFFFDC});
    waitDone("R11 done after restart");
    chk("R11 start address after restart", {pcBank, pc, modeReg}, 32'hAB12345A);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule